// File: doc/BRIEF.md
# Coin-Operated Water Vending Controller

This block is the controller of a water vending machine with one coin slot. The slot reports each accepted coin as a one-cycle strobe. One strobe is for a 1-Yuan coin, which is worth 10 Jiao. The other is for a 5-Jiao coin. A bottle costs 10 Jiao. When a coin brings the deposited value to 10 Jiao or more, the block raises its dispense output in the same cycle as that coin's strobe. The output is combinational from the stored credit and the coin inputs, so no register sits between the coin and the dispense pulse.

Only two credit levels can exist: nothing deposited, or 5 Jiao deposited. The block therefore holds a single bit of state. A parameter chooses a one-flop binary encoding or a two-flop one-hot encoding of that state. The machine gives no change. Any value above the price is forfeited when a bottle is released. A cycle in which both strobes are high is treated as invalid input and has no effect.

Top module: `water_vend_ctrl`

## Requirements
- R1: Reset is synchronous and active high. A clock edge with `rst_i` high clears the credit to zero. While `rst_i` is high, `vend_o` is 0 whatever the coin inputs are.
- R2: In a cycle with neither strobe high, `vend_o` is 0 and the credit is kept. A stored 5-Jiao credit survives any number of idle cycles.
- R3: With zero credit, a 5-Jiao strobe (`coin_half_i`=1, `coin_big_i`=0) leaves `vend_o` at 0 in that cycle. The credit becomes 5 Jiao at the next edge.
- R4: With zero credit, a 1-Yuan strobe (`coin_big_i`=1, `coin_half_i`=0) drives `vend_o` to 1 in that same cycle. The credit stays at zero.
- R5: With 5 Jiao credited, a 5-Jiao strobe drives `vend_o` to 1 in that same cycle. The credit returns to zero.
- R6: With 5 Jiao credited, a 1-Yuan strobe drives `vend_o` to 1 in that same cycle. The credit returns to zero, so the 5 Jiao of overpayment is lost.
- R7: A cycle with both strobes high gives `vend_o` = 0 and leaves the credit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| coin_big_i | input | 1 | One-cycle strobe: a 1-Yuan (10 Jiao) coin was accepted |
| coin_half_i | input | 1 | One-cycle strobe: a 5-Jiao coin was accepted |
| vend_o | output | 1 | Dispense pulse, combinational from credit and strobes |

## Verification
The credit bit cannot be seen at the ports. Its value only shows in how the block answers the next 5-Jiao coin: no pulse means zero credit, and a pulse means 5 Jiao was held. The hardest cases are the ones where credit is lost or must be kept: overpayment after a half credit, a reset that arrives with 5 Jiao held, and an invalid double strobe that arrives with 5 Jiao held. For each of these, the stimulus first builds the half credit with a single 5-Jiao strobe. It then applies the event under test and finishes with one or two 5-Jiao probe coins. The pulse pattern on those probe coins shows whether the credit was cleared or kept.

// File: rtl/water_vend_pkg.sv
package water_vend_pkg;

   // Decoded coin event for one cycle
   typedef enum logic [1:0] {
      COIN_NONE = 2'd0,
      COIN_HALF = 2'd1,
      COIN_FULL = 2'd2,
      COIN_BAD  = 2'd3
   } coin_e;

   // Encoding choice for the credit register
   typedef enum logic {
      ENC_BINARY = 1'b0,
      ENC_ONEHOT = 1'b1
   } credit_enc_e;

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
   import water_vend_pkg::*;
(
   input  logic  big_i,
   input  logic  half_i,
   output coin_e coin_o
);

   always_comb begin
      unique case ({big_i, half_i})
         2'b00:   coin_o = COIN_NONE;
         2'b01:   coin_o = COIN_HALF;
         2'b10:   coin_o = COIN_FULL;
         default: coin_o = COIN_BAD;
      endcase
   end

endmodule

// File: rtl/vend_credit_reg.sv
module vend_credit_reg
   import water_vend_pkg::*;
#(
   parameter credit_enc_e ENC = ENC_BINARY
)(
   input  logic clk_i,
   input  logic rst_i,
   input  logic nxt_half_i,
   output logic half_o
);

   if (ENC == ENC_ONEHOT) begin : g_onehot
      // bit 0: zero credit, bit 1: five Jiao held
      logic [1:0] oh_q;
      always_ff @(posedge clk_i) begin
         if (rst_i) oh_q <= 2'b01;
         else       oh_q <= nxt_half_i ? 2'b10 : 2'b01;
      end
      assign half_o = oh_q[1];
   end else begin : g_binary
      logic bit_q;
      always_ff @(posedge clk_i) begin
         if (rst_i) bit_q <= 1'b0;
         else       bit_q <= nxt_half_i;
      end
      assign half_o = bit_q;
   end

endmodule

// File: rtl/vend_next_logic.sv
module vend_next_logic
   import water_vend_pkg::*;
(
   input  logic  rst_i,
   input  logic  half_i,
   input  coin_e coin_i,
   output logic  nxt_half_o,
   output logic  vend_o
);

   always_comb begin
      nxt_half_o = half_i;
      vend_o     = 1'b0;
      unique case (coin_i)
         COIN_HALF: begin
            if (half_i) begin
               vend_o     = 1'b1;
               nxt_half_o = 1'b0;
            end else begin
               nxt_half_o = 1'b1;
            end
         end
         COIN_FULL: begin
            vend_o     = 1'b1;
            nxt_half_o = 1'b0;
         end
         default: begin
            nxt_half_o = half_i;
         end
      endcase
      if (rst_i) vend_o = 1'b0;
   end

endmodule

// File: rtl/water_vend_ctrl.sv
module water_vend_ctrl
   import water_vend_pkg::*;
#(
   parameter int          HALF_JIAO  = 5,
   parameter int          FULL_JIAO  = 10,
   parameter int          PRICE_JIAO = 10,
   parameter credit_enc_e CREDIT_ENC = ENC_BINARY
)(
   input  logic clk_i,
   input  logic rst_i,
   input  logic coin_big_i,
   input  logic coin_half_i,
   output logic vend_o
);

   localparam int HALVES_PER_PRICE = PRICE_JIAO / HALF_JIAO;

   // The two-level credit scheme only fits these value relations
   if (PRICE_JIAO != FULL_JIAO) begin : g_chk_full
      $error("water_vend_ctrl: large coin must equal the price");
   end
   if (HALVES_PER_PRICE != 2 || (PRICE_JIAO % HALF_JIAO) != 0) begin : g_chk_half
      $error("water_vend_ctrl: two small coins must equal the price");
   end

   coin_e coin_ev;
   logic  half_held;
   logic  nxt_half;

   vend_coin_decode u_dec (
      .big_i  (coin_big_i),
      .half_i (coin_half_i),
      .coin_o (coin_ev)
   );

   vend_next_logic u_nxt (
      .rst_i      (rst_i),
      .half_i     (half_held),
      .coin_i     (coin_ev),
      .nxt_half_o (nxt_half),
      .vend_o     (vend_o)
   );

   vend_credit_reg #(
      .ENC (CREDIT_ENC)
   ) u_cr (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .nxt_half_i (nxt_half),
      .half_o     (half_held)
   );

endmodule

// File: rtl/water_vend_chk.sv
module water_vend_chk (
   input logic clk_i,
   input logic rst_i,
   input logic coin_big_i,
   input logic coin_half_i,
   input logic vend_o,
   input logic half_held
);

   always_comb begin
      if (rst_i) AST_RST_SILENT: assert (!vend_o); // R1
   end

   AST_RST_CLEARS: assert property (@(posedge clk_i) rst_i |=> !half_held); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
      (!coin_big_i && !coin_half_i) |-> !vend_o); // R2
   AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
      (!coin_big_i && !coin_half_i) |=> $stable(half_held)); // R2
   AST_HALF_ARMS: assert property (@(posedge clk_i) disable iff (rst_i)
      (!half_held && coin_half_i && !coin_big_i) |-> (!vend_o ##1 half_held)); // R3
   AST_FULL_VENDS: assert property (@(posedge clk_i) disable iff (rst_i)
      (coin_big_i && !coin_half_i) |-> vend_o); // R4
   AST_PAIR_VENDS: assert property (@(posedge clk_i) disable iff (rst_i)
      (half_held && coin_half_i && !coin_big_i) |-> vend_o); // R5
   AST_VEND_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
      vend_o |=> !half_held); // R6
   AST_BOTH_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
      (coin_big_i && coin_half_i) |-> (!vend_o ##1 $stable(half_held))); // R7

endmodule

bind water_vend_ctrl water_vend_chk u_chk (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .coin_big_i  (coin_big_i),
   .coin_half_i (coin_half_i),
   .vend_o      (vend_o),
   .half_held   (half_held)
);

// File: tb/sim_water_vend_ctrl.sv
module sim_water_vend_ctrl;

   logic clk = 1'b0;
   logic rst;
   logic big;
   logic half;
   logic vend;
   int   vectors = 0;
   int   miscompares = 0;
   bit   finished = 1'b0;

   always #2 clk = ~clk;

   water_vend_ctrl u0 (
      .clk_i       (clk),
      .rst_i       (rst),
      .coin_big_i  (big),
      .coin_half_i (half),
      .vend_o      (vend)
   );

   // Drive one cycle's inputs after a falling edge, then check vend
   // before the next rising edge (Mealy output, no register delay).
   task automatic step(input logic r, input logic b, input logic h,
                       input logic exp_vend, input string req);
      @(negedge clk);
      rst  = r;
      big  = b;
      half = h;
      #1;
      vectors++;
      if (vend !== exp_vend) begin
         miscompares++;
         $display("FAIL %s: vend_o=%b expected %b (rst=%b big=%b half=%b)",
                  req, vend, exp_vend, r, b, h);
      end
   endtask

   task automatic do_reset();
      step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
      step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
   endtask

   task automatic t_reset();
      do_reset();
      // coins during reset must not vend
      step(1'b1, 1'b1, 1'b0, 1'b0, "R1");
      step(1'b1, 1'b0, 1'b1, 1'b0, "R1");
      // build half credit, then reset: credit must be gone
      step(1'b0, 1'b0, 1'b1, 1'b0, "R1");
      step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R1");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R1");
   endtask

   task automatic t_idle();
      do_reset();
      step(1'b0, 1'b0, 1'b0, 1'b0, "R2");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R2");
      for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R2");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R2");
   endtask

   task automatic t_half_first();
      do_reset();
      step(1'b0, 1'b0, 1'b1, 1'b0, "R3");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R3");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R3");
   endtask

   task automatic t_full_zero();
      do_reset();
      step(1'b0, 1'b1, 1'b0, 1'b1, "R4");
      step(1'b0, 1'b1, 1'b0, 1'b1, "R4");
      // credit still zero: a small coin must not vend
      step(1'b0, 1'b0, 1'b1, 1'b0, "R4");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R4");
   endtask

   task automatic t_half_pair();
      do_reset();
      step(1'b0, 1'b0, 1'b1, 1'b0, "R5");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R5");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R5");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R5");
   endtask

   task automatic t_overpay();
      do_reset();
      step(1'b0, 1'b0, 1'b1, 1'b0, "R6");
      step(1'b0, 1'b1, 1'b0, 1'b1, "R6");
      // excess 5 Jiao forfeited
      step(1'b0, 1'b0, 1'b1, 1'b0, "R6");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R6");
   endtask

   task automatic t_both();
      do_reset();
      // at zero credit
      step(1'b0, 1'b1, 1'b1, 1'b0, "R7");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R7");
      // now half credit; double strobe must keep it
      step(1'b0, 1'b1, 1'b1, 1'b0, "R7");
      step(1'b0, 1'b1, 1'b1, 1'b0, "R7");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R7");
   endtask

   initial begin
      rst  = 1'b1;
      big  = 1'b0;
      half = 1'b0;
      t_reset();
      t_idle();
      t_half_first();
      t_full_zero();
      t_half_pair();
      t_overpay();
      t_both();
      step(1'b0, 1'b0, 1'b0, 1'b0, "R2");
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         finished = 1'b1;
         miscompares++;
         $display("FAIL watchdog: run did not complete, expected end of stimulus");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule